// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Line Interrupt Styles

This block is a general-purpose I/O peripheral for sixteen pins, sitting behind a plain single-cycle 32-bit register bus. Software sets which lines drive and which listen, writes the levels to drive, and reads back the pin levels after a two-flop synchroniser. Each line carries a 3-bit interrupt style that picks a level or edge condition. A detected condition sets a sticky status bit, and software clears that bit by writing a 1 to it.

Lines 0 to 12 each own an active-high interrupt wire that follows the line's status bit. A clock-routing register can hand lines 14 and 15 over to two clock sources from elsewhere in the chip. A debounce-select register is held for software but has no effect on the logic.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset the direction register (offset 0x04) reads 0xFFFF, so all lines are inputs. Every other register reads 0. `pad_drive` and `irq` are all zero.
- R2: Registers are selected by `bus_addr[4:2]`: data 0x00, direction 0x04, input 0x08, status 0x0C, style for lines 0–7 at 0x10, style for lines 8–15 at 0x14, clock routing 0x18, debounce select 0x1C. Each style register keeps only bits 23:0, and its bits 31:24 read 0. Writes to the input register are ignored.
- R3: A 0 in bit n of the direction register drives line n: `pad_drive[n]` is 1 and `pad_out[n]` equals bit n of the data register. A 1 in that bit releases the line.
- R4: The input register returns the pin levels through two flops. A pin change applied before clock edge k reads back after edge k+1. A line that is driving reads back its driven level instead of `pad_in`.
- R5: Line k (0–7) takes its style from bits [3k+2:3k] at 0x10, and line k+8 from the same bits at 0x14. Code 0 (level high) or code 1 (level low) sets the status bit on every cycle that the synchronised level matches. The bit therefore sets again after a clear while the level persists.
- R6: Code 2 sets the status bit on a synchronised 0→1 change, code 3 on a 1→0 change, and code 4 on either change. The status bit sets one edge after the new level becomes readable.
- R7: Style codes 5, 6 and 7 never set a status bit.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a clear and a new event fall on the same cycle, the bit stays set.
- R9: `irq[n]` equals status bit n for lines 0 to 12.
- R10: While the clock routing register is nonzero, lines 14 and 15 drive `clk_src[0]` and `clk_src[1]` regardless of the direction register. When it is 0, those lines behave as ordinary GPIO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 16 | Pin levels as seen from outside |
| pad_out | output | 16 | Levels driven onto the pins |
| pad_drive | output | 16 | 1 where the pin driver is on |
| clk_src | input | 2 | Clock sources that can be routed to lines 14 and 15 |
| irq | output | 13 | Level-high interrupt per line 0–12 |

## Verification
A corrupted style field or detector state shows up as a status bit that is wrong in a fixed cycle: three edges after the pin change for levels, one edge after the change becomes readable for edges. It appears on the matching `irq` wire in the same cycle. A wrong synchroniser depth shifts the input read-back by one cycle, and the bench samples on both sides of the expected edge to catch that. Faults in clear priority or in direction decoding appear immediately after the bus write that triggers them.

// File: rtl/gpio_ctrl_pkg.sv
// Shared constants and types for the GPIO controller.
// Assumes a fixed register map selected by byte address bits [4:2].
package gpio_ctrl_pkg;
    localparam int STYLE_W  = 3;
    localparam int PER_REG  = 8;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 32;

    typedef enum logic [STYLE_W-1:0] {
        STY_LVL_HI = 3'd0,
        STY_LVL_LO = 3'd1,
        STY_RISE   = 3'd2,
        STY_FALL   = 3'd3,
        STY_ANY    = 3'd4
    } style_e;

    typedef enum logic [2:0] {
        RG_DOUT  = 3'd0,
        RG_DIR   = 3'd1,
        RG_PIN   = 3'd2,
        RG_STAT  = 3'd3,
        RG_STYLO = 3'd4,
        RG_STYHI = 3'd5,
        RG_CLK   = 3'd6,
        RG_DBSEL = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchroniser for a vector of pin levels.
// Assumes each bit is independent, so no bus coherency is required.
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift pin levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    // R4
    sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> q == $past(stage1));
endmodule

// File: rtl/gpio_event.sv
// Per-line condition detector. It compares the synchronised level with
// its value one cycle earlier and flags the condition picked by the
// line's 3-bit style. Assumes cur is already synchronous to clk.
module gpio_event
    import gpio_ctrl_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         cur,
    input  logic [W*STYLE_W-1:0] style,
    output logic [W-1:0]         evt
);
    logic [W-1:0] prev;

    // Remember last cycle's level for edge styles.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= cur;
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        logic [STYLE_W-1:0] sty;
        assign sty = style[i*STYLE_W +: STYLE_W];

        // Decode this line's style into a one-cycle condition.
        always_comb begin
            case (sty)
                STY_LVL_HI: evt[i] = cur[i];
                STY_LVL_LO: evt[i] = !cur[i];
                STY_RISE:   evt[i] = cur[i] && !prev[i];
                STY_FALL:   evt[i] = !cur[i] && prev[i];
                STY_ANY:    evt[i] = cur[i] != prev[i];
                default:    evt[i] = 1'b0;
            endcase
        end

        // R7
        reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sty > 3'd4) |-> !evt[i]);
        // R6
        rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sty == 3'd2 && evt[i]) |-> (cur[i] && !prev[i]));
    end
endmodule

// File: rtl/gpio_ctrl.sv
// GPIO controller top: register file, pad muxing, sticky status and
// interrupt wires. Assumes a single-cycle write strobe and a
// combinational read. Byte order and debounce are handled elsewhere.
module gpio_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int N_LINES = 16,
    parameter int N_IRQ   = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [N_LINES-1:0] pad_in,
    output logic [N_LINES-1:0] pad_out,
    output logic [N_LINES-1:0] pad_drive,
    input  logic [1:0]         clk_src,
    output logic [N_IRQ-1:0]   irq
);
    localparam int STY_BITS = PER_REG * STYLE_W;
    localparam int ALL_STY  = N_LINES * STYLE_W;

    logic [N_LINES-1:0]  dout_q, dir_q, stat_q;
    logic [STY_BITS-1:0] sty_lo_q, sty_hi_q;
    logic [DATA_W-1:0]   clkctl_q, dbsel_q;
    logic [N_LINES-1:0]  sample, synced, evt, clr;
    logic [ALL_STY-1:0]  style_all;
    logic                takeover;
    reg_sel_e            sel;

    assign sel       = reg_sel_e'(bus_addr[4:2]);
    assign takeover  = clkctl_q != '0;
    assign style_all = {sty_hi_q, sty_lo_q};

    // Register writes, except the status register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q   <= '0;
            dir_q    <= '1;
            sty_lo_q <= '0;
            sty_hi_q <= '0;
            clkctl_q <= '0;
            dbsel_q  <= '0;
        end else if (bus_wr) begin
            case (sel)
                RG_DOUT:  dout_q   <= bus_wdata[N_LINES-1:0];
                RG_DIR:   dir_q    <= bus_wdata[N_LINES-1:0];
                RG_STYLO: sty_lo_q <= bus_wdata[STY_BITS-1:0];
                RG_STYHI: sty_hi_q <= bus_wdata[STY_BITS-1:0];
                RG_CLK:   clkctl_q <= bus_wdata;
                RG_DBSEL: dbsel_q  <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Pad drivers, with clock takeover of the two top lines.
    always_comb begin
        pad_drive = ~dir_q;
        pad_out   = dout_q;
        if (takeover) begin
            pad_drive[N_LINES-1:N_LINES-2] = 2'b11;
            pad_out[N_LINES-1:N_LINES-2]   = clk_src;
        end
    end

    // A driving line samples its own level, a released line the pin.
    assign sample = (pad_drive & pad_out) | (~pad_drive & pad_in);

    gpio_sync #(.W(N_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(sample), .q(synced)
    );

    gpio_event #(.W(N_LINES)) u_event (
        .clk(clk), .rst_n(rst_n), .cur(synced), .style(style_all), .evt(evt)
    );

    assign clr = (bus_wr && sel == RG_STAT) ? bus_wdata[N_LINES-1:0] : '0;

    // Sticky status: write-one clears, a same-cycle event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | evt;
    end

    assign irq = stat_q[N_IRQ-1:0];

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            RG_DOUT:  bus_rdata[N_LINES-1:0]  = dout_q;
            RG_DIR:   bus_rdata[N_LINES-1:0]  = dir_q;
            RG_PIN:   bus_rdata[N_LINES-1:0]  = synced;
            RG_STAT:  bus_rdata[N_LINES-1:0]  = stat_q;
            RG_STYLO: bus_rdata[STY_BITS-1:0] = sty_lo_q;
            RG_STYHI: bus_rdata[STY_BITS-1:0] = sty_hi_q;
            RG_CLK:   bus_rdata               = clkctl_q;
            RG_DBSEL: bus_rdata               = dbsel_q;
            default:  bus_rdata               = '0;
        endcase
    end

    // R8
    status_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((stat_q & ~$past(stat_q) & ~$past(evt)) == '0));
    // R8
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == RG_STAT) |=> ((stat_q & $past(bus_wdata[N_LINES-1:0] & ~evt)) == '0));
    // R10
    clock_takeover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clkctl_q != '0) |-> (pad_drive[N_LINES-1:N_LINES-2] == 2'b11));
    // R9
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == stat_q[N_IRQ-1:0]));
endmodule

// File: tb/gpio_ctrl_test.sv
module gpio_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_drive;
    logic [1:0]  clk_src = 2'b10;
    logic [12:0] irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    gpio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_drive(pad_drive), .clk_src(clk_src), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] expect_evt(input int s, input logic [15:0] p0,
                                               input logic [15:0] p1, input bit after);
        logic [15:0] r;
        case (s)
            0: r = after ? (p0 | p1) : p0;
            1: r = after ? (~p0 | ~p1) : ~p0;
            2: r = after ? (p1 & ~p0) : 16'h0;
            3: r = after ? (~p1 & p0) : 16'h0;
            4: r = after ? (p1 ^ p0) : 16'h0;
            default: r = 16'h0;
        endcase
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [15:0] p0s [2];
        logic [15:0] p1s [2];
        p0s[0] = 16'h5A3C; p1s[0] = 16'h3C96;
        p0s[1] = 16'hF00F; p1s[1] = 16'h0FF0;

        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        rd(5'h04, d); check("R1 dir", d, 32'h0000FFFF);
        rd(5'h00, d); check("R1 dout", d, 32'h0);
        rd(5'h0C, d); check("R1 status", d, 32'h0);
        rd(5'h10, d); check("R1 style lo", d, 32'h0);
        rd(5'h18, d); check("R1 clkctl", d, 32'h0);
        check("R1 pad_drive", {16'h0, pad_drive}, 32'h0);
        check("R1 irq", {19'h0, irq}, 32'h0);

        // R2 style field width, debounce storage, input write ignored
        wr(5'h10, 32'hFFFFFFFF);
        rd(5'h10, d); check("R2 style lo width", d, 32'h00FFFFFF);
        wr(5'h14, 32'hABCDEF12);
        rd(5'h14, d); check("R2 style hi width", d, 32'h00CDEF12);
        wr(5'h1C, 32'h12345678);
        rd(5'h1C, d); check("R2 debounce select", d, 32'h12345678);
        wr(5'h08, 32'hFFFFFFFF);
        rd(5'h08, d); check("R2 input write ignored", d, 32'h0);
        wr(5'h10, 32'h0); wr(5'h14, 32'h0);

        // R3 and R4: lines 0-7 drive, 8-15 listen
        pad_in = 16'h5A5A;
        wr(5'h00, 32'h000000A5);
        wr(5'h04, 32'h0000FF00);
        check("R3 pad_drive", {16'h0, pad_drive}, 32'h000000FF);
        check("R3 pad_out", {16'h0, pad_out}, 32'h000000A5);
        wait_cyc(3);
        rd(5'h08, d); check("R4 read driven and pin levels", d, 32'h00005AA5);
        wr(5'h04, 32'h0000FFFF);
        wr(5'h00, 32'h0);
        wait_cyc(3);
        // R4 latency: visible after the second edge, not the first
        pad_in = 16'h0000;
        wait_cyc(3);
        pad_in = 16'h1234;
        @(negedge clk);
        rd(5'h08, d); check("R4 not after one edge", d, 32'h0);
        @(negedge clk);
        rd(5'h08, d); check("R4 after two edges", d, 32'h00001234);

        // R5 R6 R7 R9 sweep over all style codes and two pin patterns
        for (int s = 0; s < 8; s++) begin
            logic [23:0] word;
            word = '0;
            for (int k = 0; k < 8; k++) word[3*k +: 3] = 3'(s);
            wr(5'h10, {8'h0, word});
            wr(5'h14, {8'h0, word});
            for (int p = 0; p < 2; p++) begin
                logic [15:0] e0, e1;
                pad_in = p0s[p];
                wait_cyc(4);
                wr(5'h0C, 32'h0000FFFF);
                wait_cyc(3);
                e0 = expect_evt(s, p0s[p], p1s[p], 1'b0);
                rd(5'h0C, d);
                check($sformatf("R5/R7 style %0d after clear", s), d, {16'h0, e0});
                pad_in = p1s[p];
                wait_cyc(4);
                e1 = expect_evt(s, p0s[p], p1s[p], 1'b1);
                rd(5'h0C, d);
                check($sformatf("R6/R5 style %0d after change", s), d, {16'h0, e1});
                check($sformatf("R9 irq style %0d", s), {19'h0, irq}, {19'h0, e1[12:0]});
            end
        end

        // R8: zero write leaves status; rising edge status clears; level wins
        wr(5'h10, 32'h00000002); wr(5'h14, 32'h0);
        pad_in = 16'h0000;
        wait_cyc(4);
        wr(5'h0C, 32'h0000FFFF);
        pad_in = 16'h0001;
        wait_cyc(4);
        rd(5'h0C, d); check("R8 edge set", d[0], 32'h1);
        wr(5'h0C, 32'h00000000);
        rd(5'h0C, d); check("R8 write zero keeps", d[0], 32'h1);
        wr(5'h0C, 32'h00000001);
        rd(5'h0C, d); check("R8 write one clears", d[0], 32'h0);
        wr(5'h10, 32'h0);
        wait_cyc(2);
        wr(5'h0C, 32'h00000001);
        rd(5'h0C, d); check("R8 level event beats clear", d[0], 32'h1);
        check("R8 irq still set", {31'h0, irq[0]}, 32'h1);

        // R10 clock takeover
        wr(5'h18, 32'h00000001);
        check("R10 drive top lines", {30'h0, pad_drive[15:14]}, 32'h3);
        check("R10 clocks on top lines", {30'h0, pad_out[15:14]}, 32'h2);
        check("R10 other lines released", {18'h0, pad_drive[13:0]}, 32'h0);
        wr(5'h18, 32'h0);
        check("R10 released when zero", {30'h0, pad_drive[15:14]}, 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule